// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Loopback Routing

This block holds the sample queues between a host bus and a serial audio link. A transmit queue carries samples from the host toward the link, and a receive queue carries samples from the link back to the host. The host reaches both queues through a single data port. A write strobe pushes a sample, and a read strobe pops one into a registered read-data output. The block raises a DMA service request for each direction from a programmable fill threshold. Each queue also reports its occupancy and keeps sticky overrun and underrun flags.

A two-bit routing control lets software exercise one queue with no link traffic. In loopback, both host writes and host reads reach the same queue. The link side is then kept off that queue, while the other queue stays under link control. Samples are 32 bits wide, and each queue is 16 entries deep by default.

Top module: `audio_fifo_pair`

## Requirements
- R1: After reset, both levels, all four flags, `host_rdata` and `link_tx_data` are 0, `tx_dma_req` is 1 and `rx_dma_req` is 0.
- R2: With `cfg_loop_en`=0 the value of `cfg_loop_sel` has no effect. In this mode `host_wr` pushes the transmit queue, `host_rd` pops the receive queue, `link_tx_pop` pops the transmit queue and `link_rx_push` pushes the receive queue.
- R3: With `cfg_loop_en`=1 and `cfg_loop_sel`=0, `host_wr` pushes and `host_rd` pops the transmit queue. `link_tx_pop` is ignored: `link_tx_data`, `tx_level` and `tx_underrun` do not change. `link_rx_push` still pushes the receive queue.
- R4: With `cfg_loop_en`=1 and `cfg_loop_sel`=1, `host_wr` pushes and `host_rd` pops the receive queue. `link_rx_push` is ignored: `rx_level` and `rx_overrun` do not change. `link_tx_pop` still pops the transmit queue.
- R5: Each queue returns samples in the order they were pushed, and holds up to DEPTH (16) samples.
- R6: `tx_dma_req` is 1 exactly when `tx_level` is less than or equal to `tx_thresh`.
- R7: `rx_dma_req` is 1 exactly when `rx_level` is greater than `rx_thresh`.
- R8: A push to a full queue without a pop of that queue in the same cycle is discarded, and it sets that queue's overrun flag. The flag stays set until reset. A push to a full queue in a cycle that also pops it is stored.
- R9: A pop from an empty queue delivers 0 and sets that queue's sticky underrun flag. A push in the same cycle is still stored.
- R10: `tx_level` and `rx_level` are 5-bit counts (CNT_W bits). They change in the cycle after the push or pop, by at most one per cycle.
- R11: `host_rdata` and `link_tx_data` update on the clock edge that samples their pop strobe, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_loop_en | input | 1 | Routing: 0 normal, 1 loopback |
| cfg_loop_sel | input | 1 | Loopback target: 0 transmit queue, 1 receive queue |
| tx_thresh | input | 4 | Transmit request threshold |
| rx_thresh | input | 4 | Receive request threshold |
| host_wr | input | 1 | Host data-port write strobe |
| host_wdata | input | 32 | Host write sample |
| host_rd | input | 1 | Host data-port read strobe |
| host_rdata | output | 32 | Registered host read sample |
| link_tx_pop | input | 1 | Link requests the next transmit sample |
| link_tx_data | output | 32 | Registered sample given to the link |
| link_rx_push | input | 1 | Link delivers a received sample |
| link_rx_data | input | 32 | Received sample from the link |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_level | output | 5 | Receive queue occupancy |
| tx_dma_req | output | 1 | Transmit DMA service request |
| rx_dma_req | output | 1 | Receive DMA service request |
| tx_overrun | output | 1 | Sticky transmit overrun flag |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| rx_underrun | output | 1 | Sticky receive underrun flag |

## Verification
On every cycle, the assertions check that the occupancy bounds and single-step changes hold, that the error flags stay sticky, and that read data holds when there is no read. They also check that a blocked link strobe leaves the link data or receive level untouched, that a full-queue push is dropped, and that an empty pop gives zero. The request outputs are checked only at the empty and full levels. Sample ordering, the correct queue for each routing mode, and the request decision across the whole threshold range can be shown only by the bench's scenarios. The bench runs a queue-based model against the design, including random traffic with mode changes.

// File: rtl/afp_pkg.sv
package afp_pkg;

   typedef enum logic [1:0] {
      RT_NORMAL  = 2'b00,
      RT_TX_LOOP = 2'b10,
      RT_RX_LOOP = 2'b11
   } route_t;

   typedef struct packed {
      logic tx_push;
      logic tx_pop_host;
      logic tx_pop_link;
      logic rx_push;
      logic rx_push_host;
      logic rx_pop_host;
      logic host_reads_tx;
   } route_ctl_t;

   function automatic route_t decode_route(input logic en, input logic sel);
      if (!en)      return RT_NORMAL;
      else if (!sel) return RT_TX_LOOP;
      else           return RT_RX_LOOP;
   endfunction

endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic              empty,
   output logic [CNT_W-1:0]  level,
   output logic              overrun,
   output logic              underrun
);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              full, do_push, do_pop;

   assign empty   = (level == '0);
   assign full    = (level == FULL_LVL);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || pop);
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
         if (push && full && !pop) overrun  <= 1'b1;
         if (pop && empty)         underrun <= 1'b1;
      end
   end
endmodule

// File: rtl/afp_router.sv
module afp_router
   import afp_pkg::*;
(
   input  logic       loop_en,
   input  logic       loop_sel,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic       link_tx_pop,
   input  logic       link_rx_push,
   output route_ctl_t ctl
);
   route_t route;

   assign route = decode_route(loop_en, loop_sel);

   always_comb begin
      ctl = '0;
      unique case (route)
         RT_TX_LOOP: begin
            ctl.tx_push       = host_wr;
            ctl.tx_pop_host   = host_rd;
            ctl.rx_push       = link_rx_push;
            ctl.host_reads_tx = 1'b1;
         end
         RT_RX_LOOP: begin
            ctl.tx_pop_link  = link_tx_pop;
            ctl.rx_push      = host_wr;
            ctl.rx_push_host = 1'b1;
            ctl.rx_pop_host  = host_rd;
         end
         default: begin
            ctl.tx_push     = host_wr;
            ctl.tx_pop_link = link_tx_pop;
            ctl.rx_push     = link_rx_push;
            ctl.rx_pop_host = host_rd;
         end
      endcase
   end
endmodule

// File: rtl/afp_thresh.sv
module afp_thresh #(
   parameter int CNT_W = 5,
   parameter bit ABOVE = 1'b0
) (
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-2:0] thr,
   output logic             req
);
   generate
      if (ABOVE) begin : g_above
         assign req = level > {1'b0, thr};
      end else begin : g_at_or_below
         assign req = level <= {1'b0, thr};
      end
   endgenerate
endmodule

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair
   import afp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_loop_en,
   input  logic              cfg_loop_sel,
   input  logic [PTR_W-1:0]  tx_thresh,
   input  logic [PTR_W-1:0]  rx_thresh,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              link_tx_pop,
   output logic [DATA_W-1:0] link_tx_data,
   input  logic              link_rx_push,
   input  logic [DATA_W-1:0] link_rx_data,
   output logic [CNT_W-1:0]  tx_level,
   output logic [CNT_W-1:0]  rx_level,
   output logic              tx_dma_req,
   output logic              rx_dma_req,
   output logic              tx_overrun,
   output logic              tx_underrun,
   output logic              rx_overrun,
   output logic              rx_underrun
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("audio_fifo_pair: DEPTH must be a power of two >= 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("audio_fifo_pair: DATA_W must be positive");
      end
   endgenerate

   route_ctl_t        ctl;
   logic [DATA_W-1:0] tx_head, rx_head, rx_push_data, tx_out, rx_out;
   logic              tx_empty, rx_empty;

   afp_router u_router (
      .loop_en      (cfg_loop_en),
      .loop_sel     (cfg_loop_sel),
      .host_wr      (host_wr),
      .host_rd      (host_rd),
      .link_tx_pop  (link_tx_pop),
      .link_rx_push (link_rx_push),
      .ctl          (ctl)
   );

   assign rx_push_data = ctl.rx_push_host ? host_wdata : link_rx_data;

   afp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ctl.tx_push),
      .push_data (host_wdata),
      .pop       (ctl.tx_pop_host | ctl.tx_pop_link),
      .head      (tx_head),
      .empty     (tx_empty),
      .level     (tx_level),
      .overrun   (tx_overrun),
      .underrun  (tx_underrun)
   );

   afp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ctl.rx_push),
      .push_data (rx_push_data),
      .pop       (ctl.rx_pop_host),
      .head      (rx_head),
      .empty     (rx_empty),
      .level     (rx_level),
      .overrun   (rx_overrun),
      .underrun  (rx_underrun)
   );

   afp_thresh #(.CNT_W(CNT_W), .ABOVE(1'b0)) u_tx_thr (
      .level (tx_level),
      .thr   (tx_thresh),
      .req   (tx_dma_req)
   );

   afp_thresh #(.CNT_W(CNT_W), .ABOVE(1'b1)) u_rx_thr (
      .level (rx_level),
      .thr   (rx_thresh),
      .req   (rx_dma_req)
   );

   assign tx_out = tx_empty ? '0 : tx_head;
   assign rx_out = rx_empty ? '0 : rx_head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata   <= '0;
         link_tx_data <= '0;
      end else begin
         if (host_rd)         host_rdata   <= ctl.host_reads_tx ? tx_out : rx_out;
         if (ctl.tx_pop_link) link_tx_data <= tx_out;
      end
   end
endmodule

// File: rtl/afp_checker.sv
module afp_checker #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_loop_en,
   input logic              cfg_loop_sel,
   input logic              host_wr,
   input logic              host_rd,
   input logic [DATA_W-1:0] host_rdata,
   input logic              link_tx_pop,
   input logic [DATA_W-1:0] link_tx_data,
   input logic              link_rx_push,
   input logic [CNT_W-1:0]  tx_level,
   input logic [CNT_W-1:0]  rx_level,
   input logic              tx_dma_req,
   input logic              rx_dma_req,
   input logic              tx_overrun,
   input logic              rx_overrun,
   input logic              rx_underrun
);
   localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

   p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= FULL_LVL && rx_level <= FULL_LVL);

   p_tx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tx_level == $past(tx_level) || tx_level == $past(tx_level) + 1'b1
                || tx_level == $past(tx_level) - 1'b1));

   p_rx_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_level == $past(rx_level) || rx_level == $past(rx_level) + 1'b1
                || rx_level == $past(rx_level) - 1'b1));

   p_link_pop_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_loop_en && !cfg_loop_sel && link_tx_pop) |=> $stable(link_tx_data));

   p_link_push_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_loop_en && cfg_loop_sel && link_rx_push && !host_wr && !host_rd)
      |=> ($stable(rx_level) && $stable(rx_overrun)));

   p_tx_req_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level == '0) |-> tx_dma_req);

   p_rx_req_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_level == '0) |-> !rx_dma_req) and ((rx_level == FULL_LVL) |-> rx_dma_req));

   p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_loop_en && host_wr && !link_tx_pop && tx_level == FULL_LVL)
      |=> (tx_level == FULL_LVL && tx_overrun));

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_overrun || rx_overrun) |=> (($past(tx_overrun) -> tx_overrun)
                                      && ($past(rx_overrun) -> rx_overrun)));

   p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_loop_en && host_rd && rx_level == '0) |=> (host_rdata == '0 && rx_underrun));

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rd |=> $stable(host_rdata));
endmodule

bind audio_fifo_pair afp_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_loop_en  (cfg_loop_en),
   .cfg_loop_sel (cfg_loop_sel),
   .host_wr      (host_wr),
   .host_rd      (host_rd),
   .host_rdata   (host_rdata),
   .link_tx_pop  (link_tx_pop),
   .link_tx_data (link_tx_data),
   .link_rx_push (link_rx_push),
   .tx_level     (tx_level),
   .rx_level     (rx_level),
   .tx_dma_req   (tx_dma_req),
   .rx_dma_req   (rx_dma_req),
   .tx_overrun   (tx_overrun),
   .rx_overrun   (rx_overrun),
   .rx_underrun  (rx_underrun)
);

// File: tb/audio_fifo_pair_test.sv
`timescale 1ns/1ps
module audio_fifo_pair_test;
   localparam int DW = 32;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0, sel = 1'b0;
   logic [3:0]    txthr = 4'd0, rxthr = 4'd0;
   logic          hwr = 1'b0, hrd = 1'b0, lpop = 1'b0, lpush = 1'b0;
   logic [DW-1:0] hwd = '0, lpd = '0;
   logic [DW-1:0] hrdata, ltdata;
   logic [4:0]    txl, rxl;
   logic          txreq, rxreq, txo, txu, rxo, rxu;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   audio_fifo_pair uut (
      .clk(clk), .rst_n(rst_n), .cfg_loop_en(en), .cfg_loop_sel(sel),
      .tx_thresh(txthr), .rx_thresh(rxthr),
      .host_wr(hwr), .host_wdata(hwd), .host_rd(hrd), .host_rdata(hrdata),
      .link_tx_pop(lpop), .link_tx_data(ltdata),
      .link_rx_push(lpush), .link_rx_data(lpd),
      .tx_level(txl), .rx_level(rxl), .tx_dma_req(txreq), .rx_dma_req(rxreq),
      .tx_overrun(txo), .tx_underrun(txu), .rx_overrun(rxo), .rx_underrun(rxu)
   );

   // behavioural reference
   logic [DW-1:0] txq[$], rxq[$];
   logic [DW-1:0] m_hr, m_ld, v;
   bit m_txo, m_txu, m_rxo, m_rxu;
   bit t_push, t_pop_h, t_pop_l, r_push, r_from_h, r_pop, h_tx, t_full, r_full;

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_hr = '0; m_ld = '0;
         m_txo = 0; m_txu = 0; m_rxo = 0; m_rxu = 0;
      end else begin
         t_push = 0; t_pop_h = 0; t_pop_l = 0; r_push = 0; r_from_h = 0; r_pop = 0; h_tx = 0;
         if (!en) begin
            t_push = hwr; t_pop_l = lpop; r_push = lpush; r_pop = hrd;
         end else if (!sel) begin
            t_push = hwr; t_pop_h = hrd; r_push = lpush; h_tx = 1;
         end else begin
            t_pop_l = lpop; r_push = hwr; r_from_h = 1; r_pop = hrd;
         end
         t_full = (txq.size() == DEPTH);
         r_full = (rxq.size() == DEPTH);
         if (t_pop_h || t_pop_l) begin
            if (txq.size() == 0) begin v = '0; m_txu = 1; end
            else v = txq.pop_front();
            if (t_pop_h) m_hr = v; else m_ld = v;
         end
         if (r_pop) begin
            if (rxq.size() == 0) begin v = '0; m_rxu = 1; end
            else v = rxq.pop_front();
            if (!h_tx) m_hr = v;
         end
         if (t_push) begin
            if (t_full && !(t_pop_h || t_pop_l)) m_txo = 1;
            else txq.push_back(hwd);
         end
         if (r_push) begin
            if (r_full && !r_pop) m_rxo = 1;
            else rxq.push_back(r_from_h ? hwd : lpd);
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R11 host_rdata", 64'(hrdata), 64'(m_hr));
      chk("R11 link_tx_data", 64'(ltdata), 64'(m_ld));
      chk("R10 tx_level", 64'(txl), 64'(txq.size()));
      chk("R10 rx_level", 64'(rxl), 64'(rxq.size()));
      chk("R6 tx_dma_req", 64'(txreq), 64'(txq.size() <= int'(txthr)));
      chk("R7 rx_dma_req", 64'(rxreq), 64'(rxq.size() > int'(rxthr)));
      chk("R8 tx_overrun", 64'(txo), 64'(m_txo));
      chk("R8 rx_overrun", 64'(rxo), 64'(m_rxo));
      chk("R9 tx_underrun", 64'(txu), 64'(m_txu));
      chk("R9 rx_underrun", 64'(rxu), 64'(m_rxu));
   endtask

   task automatic step(input bit w, input logic [DW-1:0] wd, input bit r,
                       input bit lp, input bit lu, input logic [DW-1:0] ld);
      hwr = w; hwd = wd; hrd = r; lpop = lp; lpush = lu; lpd = ld;
      @(posedge clk);
      @(negedge clk);
      hwr = 0; hrd = 0; lpop = 0; lpush = 0;
      compare_all();
   endtask

   task automatic idle();
      step(0, '0, 0, 0, 0, '0);
   endtask

   task automatic do_reset();
      rst_n = 0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] keep;
      @(negedge clk);
      do_reset();
      // R1 reset state
      chk("R1 tx_level", 64'(txl), 0);
      chk("R1 rx_level", 64'(rxl), 0);
      chk("R1 tx_dma_req", 64'(txreq), 1);
      chk("R1 rx_dma_req", 64'(rxreq), 0);
      chk("R1 flags", 64'({txo, txu, rxo, rxu}), 0);
      chk("R1 host_rdata", 64'(hrdata), 0);

      // R2 normal routing, select ignored while loop disabled
      en = 0; sel = 1; txthr = 4'd2; rxthr = 4'd1;
      step(1, 32'hA1, 0, 0, 0, '0);
      step(1, 32'hB2, 0, 0, 0, '0);
      chk("R6 req at level==thr", 64'(txreq), 1);
      step(1, 32'hC3, 0, 0, 0, '0);
      chk("R6 req above thr", 64'(txreq), 0);
      step(0, '0, 0, 1, 0, '0);
      chk("R2 link pops tx", 64'(ltdata), 32'hA1);
      step(0, '0, 0, 0, 1, 32'h51);
      chk("R7 rx req at level==thr", 64'(rxreq), 0);
      step(0, '0, 0, 0, 1, 32'h52);
      chk("R7 rx req above thr", 64'(rxreq), 1);
      step(0, '0, 1, 0, 0, '0);
      chk("R2 host pops rx", 64'(hrdata), 32'h51);
      step(0, '0, 0, 1, 0, '0);
      chk("R5 order second", 64'(ltdata), 32'hB2);
      step(0, '0, 0, 1, 0, '0);
      chk("R5 order third", 64'(ltdata), 32'hC3);
      step(0, '0, 1, 0, 0, '0);

      // R8 overrun, R9 underrun
      do_reset();
      en = 0; sel = 0;
      for (int i = 0; i < DEPTH; i++) step(1, 32'h100 + i, 0, 0, 0, '0);
      chk("R5 full level", 64'(txl), DEPTH);
      step(1, 32'hDEAD, 0, 0, 0, '0);
      chk("R8 dropped level", 64'(txl), DEPTH);
      chk("R8 overrun set", 64'(txo), 1);
      step(1, 32'h200, 0, 1, 0, '0);
      chk("R8 push with pop on full", 64'(txl), DEPTH);
      chk("R8 pop on full data", 64'(ltdata), 32'h100);
      for (int i = 1; i < DEPTH; i++) step(0, '0, 0, 1, 0, '0);
      step(0, '0, 0, 1, 0, '0);
      chk("R8 accepted sample last", 64'(ltdata), 32'h200);
      chk("R8 overrun sticky", 64'(txo), 1);
      step(0, '0, 0, 1, 0, '0);
      chk("R9 empty pop zero", 64'(ltdata), 0);
      chk("R9 underrun set", 64'(txu), 1);
      step(0, '0, 1, 0, 1, 32'h77);
      chk("R9 push kept during empty pop", 64'(rxl), 1);
      chk("R9 rx empty pop zero", 64'(hrdata), 0);

      // R3 transmit loopback
      do_reset();
      en = 1; sel = 0;
      step(1, 32'hE1, 0, 0, 0, '0);
      step(1, 32'hE2, 0, 0, 0, '0);
      keep = ltdata;
      step(0, '0, 0, 1, 0, '0);
      chk("R3 link pop ignored data", 64'(ltdata), 64'(keep));
      chk("R3 link pop ignored level", 64'(txl), 2);
      chk("R3 link pop no underrun", 64'(txu), 0);
      step(0, '0, 1, 0, 0, '0);
      chk("R3 host reads tx", 64'(hrdata), 32'hE1);
      step(0, '0, 0, 0, 1, 32'h33);
      chk("R3 link still pushes rx", 64'(rxl), 1);

      // R4 receive loopback
      do_reset();
      en = 1; sel = 1;
      step(1, 32'hF1, 0, 0, 0, '0);
      chk("R4 host writes rx", 64'(rxl), 1);
      chk("R4 tx untouched", 64'(txl), 0);
      step(0, '0, 0, 0, 1, 32'h99);
      chk("R4 link push ignored", 64'(rxl), 1);
      chk("R4 link push no overrun", 64'(rxo), 0);
      step(0, '0, 1, 0, 0, '0);
      chk("R4 host reads rx", 64'(hrdata), 32'hF1);
      en = 0;
      step(1, 32'hF7, 0, 0, 0, '0);
      en = 1;
      step(0, '0, 0, 1, 0, '0);
      chk("R4 link still pops tx", 64'(ltdata), 32'hF7);

      // random traffic with mode changes
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         if (c % 64 == 0) begin
            en = 1'($urandom); sel = 1'($urandom);
            txthr = 4'($urandom); rxthr = 4'($urandom);
         end
         step(1'($urandom), $urandom, 1'($urandom), 1'($urandom),
              1'($urandom), $urandom);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule